// File: doc/BRIEF.md
# Segmented Fetch-Execute Microsequencer

This block is a minimal 16-bit core that runs a very small instruction set out of a byte-wide memory. For every byte it fetches, it forms a 20-bit physical address from a 16-bit code segment and a 16-bit instruction pointer. The segment is shifted left by four bits and added to the pointer plus the byte index. The core drives that address on a read port and waits for the memory's ready handshake before it stores the byte.

Each instruction runs through a fixed order: address computation, bus read, and buffering of every instruction byte. After that the instruction pointer moves past the instruction, and only then does the instruction execute. The supported opcodes are a 16-bit immediate load of the accumulator, 8-bit immediate loads of its low half and its high half, and a stop instruction. Any other first byte stops the core and raises an illegal-opcode flag. Debug outputs expose the segment, the pointer and the accumulator, and memory latency sets the cycles per instruction.

Top module: `seg_fetch_core`

## Requirements
- R1: Every fetch address equals (segment << 4) + ((pointer + byte index) mod 65536), truncated to 20 bits, so it wraps above FFFFFh.
- R2: After reset with segment 2000h and pointer 0000h, the first fetch reads physical address 20000h, and the following bytes of straight-line code read consecutive addresses.
- R3: Opcode B8h takes 3 bytes. Its second byte is written to accumulator bits 7..0 and its third byte to bits 15..8 (B8 23 01 gives 0123h).
- R4: Opcode B0h takes 2 bytes and writes its immediate to accumulator bits 7..0 only. Opcode B4h takes 2 bytes and writes its immediate to bits 15..8 only.
- R5: The pointer grows by the instruction length before the instruction executes, and it wraps modulo 65536.
- R6: Opcode F4h takes 1 byte. Once it executes, `halted` is 1 and stays 1, no further reads are issued, and the pointer rests just past the F4h byte.
- R7: Any other first byte sets `illegal` and `halted`, and leaves the pointer and the accumulator unchanged.
- R8: `mem_rd` stays high with a stable `mem_addr` until `mem_ready`. An instruction of L bytes costs 2L+2 cycles plus its wait cycles. An illegal opcode costs 2 cycles plus its wait cycles.
- R9: While reset is low, segment, pointer and accumulator hold their parameter reset values, and `mem_rd`, `halted` and `illegal` are 0. The core starts work two clock edges after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 20 | Physical byte address of the current read |
| mem_rd | output | 1 | Read strobe, held until ready |
| mem_rdata | input | 8 | Read data byte |
| mem_ready | input | 1 | Memory has placed the byte on mem_rdata |
| halted | output | 1 | Core has stopped |
| illegal | output | 1 | Core stopped on an undefined opcode |
| dbg_cs | output | 16 | Code segment register |
| dbg_ip | output | 16 | Instruction pointer register |
| dbg_ax | output | 16 | Accumulator register |

## Verification
The number of edges from reset release to `halted` is known for each program. It is two synchronizer edges, plus 2L+2 edges per completed instruction, plus one edge per wait cycle (R8). The bench counts falling edges from release and compares that count to the figure carried in each vector, so every result is read half a cycle after the edge that registers it. The fetch addresses are logged on the falling edge of every completed handshake and compared with the address each byte should have.

// File: rtl/seg_fetch_pkg.sv
package seg_fetch_pkg;

  typedef enum logic [2:0] {
    ST_ADDR = 3'd0,
    ST_BUS  = 3'd1,
    ST_ADV  = 3'd2,
    ST_EXEC = 3'd3,
    ST_STOP = 3'd4
  } seq_state_t;

  typedef enum logic [1:0] {
    K_LOAD_W  = 2'd0,
    K_LOAD_LO = 2'd1,
    K_LOAD_HI = 2'd2,
    K_STOP    = 2'd3
  } op_kind_t;

  localparam logic [7:0] OPC_LOAD_W  = 8'hB8;
  localparam logic [7:0] OPC_LOAD_LO = 8'hB0;
  localparam logic [7:0] OPC_LOAD_HI = 8'hB4;
  localparam logic [7:0] OPC_STOP    = 8'hF4;

endpackage

// File: rtl/seg_rst_sync.sv
module seg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen #(
  parameter int SEG_W  = 16,
  parameter int PHYS_W = 20
) (
  input  logic [SEG_W-1:0]  seg,
  input  logic [SEG_W-1:0]  off,
  output logic [PHYS_W-1:0] phys
);
  localparam int SHIFT = PHYS_W - SEG_W;

  logic [PHYS_W-1:0] seg_ext;
  logic [PHYS_W-1:0] off_ext;

  assign seg_ext = PHYS_W'({seg, {SHIFT{1'b0}}});
  assign off_ext = PHYS_W'(off);
  assign phys    = seg_ext + off_ext;
endmodule

// File: rtl/seg_op_decode.sv
module seg_op_decode
  import seg_fetch_pkg::*;
(
  input  logic [7:0] opcode,
  output logic       legal,
  output logic [1:0] len,
  output op_kind_t   kind
);
  always_comb begin
    legal = 1'b1;
    len   = 2'd1;
    kind  = K_STOP;
    case (opcode)
      OPC_LOAD_W:  begin len = 2'd3; kind = K_LOAD_W;  end
      OPC_LOAD_LO: begin len = 2'd2; kind = K_LOAD_LO; end
      OPC_LOAD_HI: begin len = 2'd2; kind = K_LOAD_HI; end
      OPC_STOP:    begin len = 2'd1; kind = K_STOP;    end
      default:     begin legal = 1'b0; end
    endcase
  end
endmodule

// File: rtl/seg_acc_file.sv
module seg_acc_file #(
  parameter int              W     = 16,
  parameter logic [W-1:0]    RST_V = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [W/8-1:0]       lane_we,
  input  logic [W-1:0]         wdata,
  output logic [W-1:0]         q
);
  localparam int LANES = W / 8;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          q[8*g +: 8] <= RST_V[8*g +: 8];
      else if (lane_we[g]) q[8*g +: 8] <= wdata[8*g +: 8];
    end
  end
endmodule

// File: rtl/seg_fetch_core.sv
module seg_fetch_core
  import seg_fetch_pkg::*;
#(
  parameter int                DATA_W  = 16,
  parameter int                PHYS_W  = 20,
  parameter logic [DATA_W-1:0] RST_CS  = 16'h2000,
  parameter logic [DATA_W-1:0] RST_IP  = 16'h0000,
  parameter logic [DATA_W-1:0] RST_AX  = 16'h0000
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [PHYS_W-1:0] mem_addr,
  output logic              mem_rd,
  input  logic [7:0]        mem_rdata,
  input  logic              mem_ready,
  output logic              halted,
  output logic              illegal,
  output logic [DATA_W-1:0] dbg_cs,
  output logic [DATA_W-1:0] dbg_ip,
  output logic [DATA_W-1:0] dbg_ax
);
  localparam int BUF_BYTES = 3;
  localparam int IDX_W     = 2;
  localparam int LANES     = DATA_W / 8;

  logic rst_core_n;

  seg_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_core_n)
  );

  seq_state_t        state_q, state_d;
  logic [DATA_W-1:0] cs_q;
  logic [DATA_W-1:0] ip_q, ip_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [PHYS_W-1:0] addr_q, addr_d;
  logic [7:0]        ibuf_q [1:BUF_BYTES-1];
  logic [7:0]        ibuf_d [1:BUF_BYTES-1];
  logic [1:0]        len_q, len_d;
  op_kind_t          kind_q, kind_d;
  logic              halted_q, halted_d;
  logic              illegal_q, illegal_d;

  logic [PHYS_W-1:0] phys_w;
  logic              dec_legal;
  logic [1:0]        dec_len;
  op_kind_t          dec_kind;
  logic [LANES-1:0]  ax_we;
  logic [DATA_W-1:0] ax_wdata;
  logic [DATA_W-1:0] ax_w;

  seg_addr_gen #(.SEG_W(DATA_W), .PHYS_W(PHYS_W)) u_addr_gen (
    .seg(cs_q), .off(ip_q + DATA_W'(idx_q)), .phys(phys_w)
  );

  seg_op_decode u_decode (
    .opcode(mem_rdata), .legal(dec_legal), .len(dec_len), .kind(dec_kind)
  );

  seg_acc_file #(.W(DATA_W), .RST_V(RST_AX)) u_acc (
    .clk(clk), .rst_n(rst_core_n), .lane_we(ax_we), .wdata(ax_wdata), .q(ax_w)
  );

  // Next-state logic
  always_comb begin
    state_d   = state_q;
    ip_d      = ip_q;
    idx_d     = idx_q;
    addr_d    = addr_q;
    ibuf_d    = ibuf_q;
    len_d     = len_q;
    kind_d    = kind_q;
    halted_d  = halted_q;
    illegal_d = illegal_q;
    ax_we     = '0;
    ax_wdata  = '0;
    case (state_q)
      ST_ADDR: begin
        addr_d  = phys_w;
        state_d = ST_BUS;
      end
      ST_BUS: begin
        if (mem_ready) begin
          if (idx_q == '0) begin
            if (!dec_legal) begin
              halted_d  = 1'b1;
              illegal_d = 1'b1;
              state_d   = ST_STOP;
            end else begin
              len_d  = dec_len;
              kind_d = dec_kind;
              if (dec_len == 2'd1) begin
                state_d = ST_ADV;
              end else begin
                idx_d   = IDX_W'(1);
                state_d = ST_ADDR;
              end
            end
          end else begin
            ibuf_d[idx_q] = mem_rdata;
            if (idx_q + IDX_W'(1) == len_q) begin
              idx_d   = '0;
              state_d = ST_ADV;
            end else begin
              idx_d   = idx_q + IDX_W'(1);
              state_d = ST_ADDR;
            end
          end
        end
      end
      ST_ADV: begin
        ip_d    = ip_q + DATA_W'(len_q);
        state_d = ST_EXEC;
      end
      ST_EXEC: begin
        state_d = ST_ADDR;
        case (kind_q)
          K_LOAD_W: begin
            ax_we    = '1;
            ax_wdata = {ibuf_q[2], ibuf_q[1]};
          end
          K_LOAD_LO: begin
            ax_we    = LANES'(1);
            ax_wdata = DATA_W'(ibuf_q[1]);
          end
          K_LOAD_HI: begin
            ax_we    = LANES'(2);
            ax_wdata = {ibuf_q[1], 8'h00};
          end
          default: begin
            halted_d = 1'b1;
            state_d  = ST_STOP;
          end
        endcase
      end
      default: state_d = ST_STOP;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      state_q   <= ST_ADDR;
      cs_q      <= RST_CS;
      ip_q      <= RST_IP;
      idx_q     <= '0;
      addr_q    <= '0;
      len_q     <= 2'd1;
      kind_q    <= K_STOP;
      halted_q  <= 1'b0;
      illegal_q <= 1'b0;
      for (int i = 1; i < BUF_BYTES; i++) ibuf_q[i] <= '0;
    end else begin
      state_q   <= state_d;
      cs_q      <= cs_q;
      ip_q      <= ip_d;
      idx_q     <= idx_d;
      addr_q    <= addr_d;
      len_q     <= len_d;
      kind_q    <= kind_d;
      halted_q  <= halted_d;
      illegal_q <= illegal_d;
      ibuf_q    <= ibuf_d;
    end
  end

  assign mem_rd   = (state_q == ST_BUS);
  assign mem_addr = addr_q;
  assign halted   = halted_q;
  assign illegal  = illegal_q;
  assign dbg_cs   = cs_q;
  assign dbg_ip   = ip_q;
  assign dbg_ax   = ax_w;
endmodule

// File: rtl/seg_fetch_core_chk.sv
module seg_fetch_core_chk
  import seg_fetch_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        mem_rd,
  input logic        mem_ready,
  input logic [19:0] mem_addr,
  input logic        halted,
  input logic        illegal,
  input logic [15:0] ip,
  input logic [15:0] ax,
  input seq_state_t  state
);
  a_r6_no_fetch_halted: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_rd);

  a_r6_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  a_r8_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !mem_ready) |=> (mem_rd && $stable(mem_addr)));

  a_r7_illegal_stops: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> halted);

  a_r5_ip_moves_before_exec: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ip) |-> ($past(state) == ST_ADV && state == ST_EXEC));

  a_r3_ax_moves_in_exec: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ax) |-> $past(state) == ST_EXEC);

  a_r7_ip_frozen_on_illegal: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(illegal) |-> $stable(ip));
endmodule

bind seg_fetch_core seg_fetch_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd), .mem_ready(mem_ready),
  .mem_addr(mem_addr), .halted(halted), .illegal(illegal),
  .ip(ip_q), .ax(ax_w), .state(state_q)
);

// File: tb/seg_fetch_core_bench.sv
module seg_fetch_core_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [63:0] prog;
    logic [3:0]  nbytes;
    logic [1:0]  lat;
    logic [15:0] ax;
    logic [15:0] ip;
    logic        ill;
    logic [7:0]  cyc;
  } vec_t;

  // cycles = 2 (sync) + sum(2L+2) + waits ; illegal opcode costs 2 + waits
  localparam vec_t VECS [6] = '{
    '{64'h00000000F40123B8, 4'd4, 2'd0, 16'h0123, 16'h0004, 1'b0, 8'd14},
    '{64'h0000F411B0EEFFB8, 4'd6, 2'd1, 16'hEE11, 16'h0006, 1'b0, 8'd26},
    '{64'h0000F4ABB41234B8, 4'd6, 2'd2, 16'hAB34, 16'h0006, 1'b0, 8'd32},
    '{64'h000000F4A5B45AB0, 4'd5, 2'd3, 16'hA55A, 16'h0005, 1'b0, 8'd33},
    '{64'h000000000F0201B8, 4'd4, 2'd1, 16'h0201, 16'h0003, 1'b1, 8'd16},
    '{64'h00000000000000F4, 4'd1, 2'd0, 16'h0000, 16'h0001, 1'b0, 8'd6}
  };

  logic clk, rst_n;
  logic [1:0] lat;
  int checks, failures;

  // main instance
  logic [19:0] a0; logic rd0, rdy0, h0, il0; logic [7:0] d0;
  logic [15:0] cs0, ip0, ax0;
  logic [7:0] mem0 [16];
  int w0;
  // wrap instance
  logic [19:0] a1; logic rd1, rdy1, h1, il1; logic [7:0] d1;
  logic [15:0] cs1, ip1, ax1;
  logic [7:0] mem1 [16];
  int w1;

  seg_fetch_core u_seg_fetch_core (
    .clk(clk), .rst_n(rst_n), .mem_addr(a0), .mem_rd(rd0), .mem_rdata(d0),
    .mem_ready(rdy0), .halted(h0), .illegal(il0), .dbg_cs(cs0), .dbg_ip(ip0), .dbg_ax(ax0));

  seg_fetch_core #(.RST_CS(16'hFFFF), .RST_IP(16'hFFFE), .RST_AX(16'h5500)) u_seg_fetch_core_wrap (
    .clk(clk), .rst_n(rst_n), .mem_addr(a1), .mem_rd(rd1), .mem_rdata(d1),
    .mem_ready(rdy1), .halted(h1), .illegal(il1), .dbg_cs(cs1), .dbg_ip(ip1), .dbg_ax(ax1));

  assign d0   = mem0[a0[3:0]];
  assign d1   = mem1[a1[3:0]];
  assign rdy0 = rd0 && (w0 >= int'(lat));
  assign rdy1 = rd1 && (w1 >= int'(lat));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    w0 <= (rd0 && !rdy0) ? w0 + 1 : 0;
    w1 <= (rd1 && !rdy1) ? w1 + 1 : 0;
  end

  // fetch logs
  logic [19:0] log0 [16]; int n0;
  logic [19:0] log1 [16]; int n1;
  always @(negedge clk) begin
    if (!rst_n) begin n0 <= 0; n1 <= 0; end
    else begin
      if (rd0 && rdy0 && n0 < 16) begin log0[n0] <= a0; n0 <= n0 + 1; end
      if (rd1 && rdy1 && n1 < 16) begin log1[n1] <= a1; n1 <= n1 + 1; end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // watchdog
  int tick;
  initial begin
    tick = 0;
    forever begin
      @(posedge clk);
      tick++;
      if (tick > 100000) begin
        checks++; failures++;
        $display("FAIL watchdog expired actual=%0d expected<=100000", tick);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    checks = 0; failures = 0; lat = 2'd0; rst_n = 1'b0;
    w0 = 0; w1 = 0;
    for (int i = 0; i < 16; i++) begin mem0[i] = 8'h00; mem1[i] = 8'h00; end
    mem1[4'hE] = 8'hB0; mem1[4'hF] = 8'h77; mem1[4'h0] = 8'hF4;

    // R9: state while reset held
    repeat (2) @(negedge clk);
    check(rd0 == 1'b0 && h0 == 1'b0 && il0 == 1'b0, "R9", "strobes in reset",
          {29'd0, rd0, h0, il0}, 32'd0);
    check(cs0 == 16'h2000 && ip0 == 16'h0000, "R9", "cs/ip in reset",
          {cs0, ip0}, 32'h20000000);
    check(ax0 == 16'h0000 && ax1 == 16'h5500, "R9", "ax in reset", {ax0, ax1}, 32'h00005500);

    // R9: nothing happens during the two synchronizer edges
    rst_n = 1'b1;
    @(negedge clk);
    check(rd0 == 1'b0, "R9", "no strobe after first edge", {31'd0, rd0}, 32'd0);
    @(negedge clk);
    check(rd0 == 1'b0, "R9", "no strobe after second edge", {31'd0, rd0}, 32'd0);

    // table walk
    for (int v = 0; v < 6; v++) begin
      int cyc;
      logic [15:0] ip_hold;
      do_reset();
      for (int i = 0; i < 16; i++) mem0[i] = (i < 8) ? VECS[v].prog[8*i +: 8] : 8'h00;
      lat = VECS[v].lat;
      rst_n = 1'b1;
      cyc = 0;
      while (!h0 && cyc < 300) begin
        @(negedge clk);
        cyc++;
      end
      check(cyc == int'(VECS[v].cyc), "R8", $sformatf("vec%0d cycles to stop", v),
            cyc, VECS[v].cyc);
      check(ax0 == VECS[v].ax, VECS[v].ill ? "R7" : "R3/R4",
            $sformatf("vec%0d accumulator", v), ax0, VECS[v].ax);
      check(ip0 == VECS[v].ip, VECS[v].ill ? "R7" : "R5",
            $sformatf("vec%0d pointer", v), ip0, VECS[v].ip);
      check(il0 == VECS[v].ill, "R7", $sformatf("vec%0d illegal flag", v), il0, VECS[v].ill);
      check(n0 == int'(VECS[v].nbytes), "R2", $sformatf("vec%0d bytes fetched", v),
            n0, VECS[v].nbytes);
      for (int i = 0; i < n0; i++)
        check(log0[i] == 20'h20000 + 20'(i), "R2", $sformatf("vec%0d fetch addr %0d", v, i),
              log0[i], 20'h20000 + 20'(i));
      // R6: no reads and no pointer motion once stopped
      ip_hold = ip0;
      for (int k = 0; k < 5; k++) begin
        @(negedge clk);
        check(rd0 == 1'b0 && h0 == 1'b1 && ip0 == ip_hold, "R6",
              $sformatf("vec%0d quiet after stop", v), {15'd0, rd0, ip0}, {16'd0, ip_hold});
      end
    end

    // R4: byte halves written alone, checked at the port mid-run
    do_reset();
    for (int i = 0; i < 16; i++) mem0[i] = 8'h00;
    mem0[0] = 8'hB8; mem0[1] = 8'hCD; mem0[2] = 8'hAB;
    mem0[3] = 8'hB4; mem0[4] = 8'h99; mem0[5] = 8'hB0; mem0[6] = 8'h11; mem0[7] = 8'hF4;
    lat = 2'd0;
    rst_n = 1'b1;
    repeat (10) @(negedge clk);   // 2 sync + 8 for the 3-byte load
    check(ax0 == 16'hABCD, "R3", "word load low byte first", ax0, 16'hABCD);
    repeat (6) @(negedge clk);    // 2-byte load of high half
    check(ax0 == 16'h99CD, "R4", "high half only", ax0, 16'h99CD);
    repeat (6) @(negedge clk);    // 2-byte load of low half
    check(ax0 == 16'h9911, "R4", "low half only", ax0, 16'h9911);
    check(ip0 == 16'h0007, "R5", "pointer after three loads", ip0, 16'h0007);

    // R1/R5: address and pointer wrap on the second instance
    do_reset();
    lat = 2'd1;
    rst_n = 1'b1;
    for (int k = 0; k < 60 && !h1; k++) @(negedge clk);
    check(n1 == 3, "R1", "wrap bytes fetched", n1, 3);
    check(log1[0] == 20'h0FFEE, "R1", "wrap addr 0", log1[0], 20'h0FFEE);
    check(log1[1] == 20'h0FFEF, "R1", "wrap addr 1", log1[1], 20'h0FFEF);
    check(log1[2] == 20'hFFFF0, "R1", "wrap addr 2", log1[2], 20'hFFFF0);
    check(ip1 == 16'h0001, "R5", "pointer wraps", ip1, 16'h0001);
    check(ax1 == 16'h5577, "R4", "low load keeps high half", ax1, 16'h5577);
    check(h1 == 1'b1 && il1 == 1'b0, "R6", "wrap run stopped cleanly", {h1, il1}, 2'b10);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule